// File: doc/BRIEF.md
# UART FIFO Watermark Interrupt Controller

This block sits between the serial shifters of a UART and a processor register port. It buffers received characters in a receive queue, and bytes waiting to go out in a transmit queue. From the fill levels of these queues and from line events, it raises one service interrupt. The receiver pushes each character together with its error flags. The transmitter pulls bytes one at a time through a valid/pop pair. A strobe, asserted once per character period, drives an idle timer. This timer flags data that is waiting in the receive queue below the threshold.

Software sets two thresholds. The receive threshold is a fill level at which reading becomes worthwhile. The transmit threshold is a count of bytes still queued, at or below which refilling becomes worthwhile, so a threshold of 8 in a 32-deep queue guarantees room for 24 more bytes. Sticky event status is cleared by writing ones. Each interrupt source has its own enable bit.

Register map, with addresses on `reg_addr`:
- 0: receive word (read, pops).
- 1: transmit byte (write, pushes).
- 2: status.
- 3: interrupt enables.
- 4: thresholds.
- 5: queue levels.

Top module: `uart_fifo_irq`

## Requirements
- R1: Each queue holds 32 entries. Register 5 reads the receive level in bits 5:0 and the transmit level in bits 13:8. A write to register 1 while the transmit queue is full is dropped.
- R2: Reading register 0 returns the oldest receive entry and removes it. The entry carries the character in bits 7:0, frame error in bit 8, parity error in bit 9, overrun in bit 10, break in bit 11 and valid in bit 15. A read from an empty queue returns zero and changes nothing.
- R3: Status bit 0 (receive ready) is 1 while the receive level is at least the receive threshold. The threshold sits in register 4 bits 5:0 and resets to 24.
- R4: Status bit 2 (transmit ready) is 1 while the transmit level is at most the transmit threshold. The threshold sits in register 4 bits 13:8 and resets to 8.
- R5: Status bit 4 (data present) is 1 while the receive queue holds at least one entry.
- R6: Status bit 1 (aging) becomes 1 on the eighth `char_tick` counted while the receive queue is non-empty. Every received character and every receive read restarts the count.
- R7: Status bit 3 (break) becomes 1 when a character is pushed with its break flag set.
- R8: Writing 1 to status bit 1 or bit 3 clears that bit, and writing all ones clears both. Bits 0, 2 and 4 follow the queue levels and are unaffected by status writes.
- R9: `irq` is the OR of each status bit 0 to 3 ANDed with the same bit of register 3. The break enable acts alone, whatever the other enables are. All enables reset to 0.
- R10: A push into a full receive queue, with no read in the same cycle, drops the character and sets the overrun bit of the newest stored entry.
- R11: `tx_valid` is 1 while the transmit queue is non-empty. `tx_byte` shows the oldest byte, and `tx_pop` removes it, in write order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| rx_push | input | 1 | Receiver delivers a character |
| rx_char | input | 8 | Received character |
| rx_frm_err | input | 1 | Frame error of the character |
| rx_par_err | input | 1 | Parity error of the character |
| rx_brk | input | 1 | Character is a break |
| tx_pop | input | 1 | Transmitter takes the head byte |
| tx_byte | output | 8 | Head byte of the transmit queue |
| tx_valid | output | 1 | Transmit queue non-empty |
| char_tick | input | 1 | One pulse per character period |
| irq | output | 1 | Service interrupt |

## Verification
Receive traffic is driven in three patterns:
- A short burst with mixed error flags, which separates the entry format from the threshold logic.
- A fill through the threshold and past full, which isolates the exact cycle receive ready rises and the overrun marking of the newest entry.
- Sparse characters interleaved with character ticks, which tell a restarted aging count from one that kept running.

Transmit traffic is driven twice:
- A partial load drained across the threshold, which shows the level comparison counting queued bytes rather than free space.
- An overfill, which shows that the extra write is dropped.

Break status is tested with only its own enable set, to show that it does not depend on the other sources.

// File: rtl/uart_fifo_irq.sv
module uart_fifo_irq #(
  parameter int DEPTH      = 32,
  parameter int AGE_CHARS  = 8,
  parameter int RX_THR_RST = 24,
  parameter int TX_THR_RST = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        rx_push,
  input  logic [7:0]  rx_char,
  input  logic        rx_frm_err,
  input  logic        rx_par_err,
  input  logic        rx_brk,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  output logic        tx_valid,
  input  logic        char_tick,
  output logic        irq
);
  localparam int AW  = $clog2(DEPTH);
  localparam int CW  = AW + 1;
  localparam int GW  = $clog2(AGE_CHARS + 1);
  localparam logic [2:0] A_RXD = 3'd0, A_TXD = 3'd1, A_STS = 3'd2,
                         A_ENA = 3'd3, A_THR = 3'd4, A_LVL = 3'd5;

  logic [11:0]   rx_mem [DEPTH];
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp, tx_wp, tx_rp;
  logic [CW-1:0] rx_cnt, tx_cnt, rx_thr, tx_thr;
  logic [GW-1:0] age_cnt;
  logic [3:0]    irq_en;
  logic          age_sts, brk_sts;

  wire rx_full  = rx_cnt == CW'(DEPTH);
  wire tx_full  = tx_cnt == CW'(DEPTH);
  wire rx_pop   = reg_rd && reg_addr == A_RXD && rx_cnt != '0;
  wire rx_wr    = rx_push && (!rx_full || rx_pop);
  wire rx_ovr   = rx_push && rx_full && !rx_pop;
  wire tx_take  = tx_pop && tx_cnt != '0;
  wire tx_wr    = reg_wr && reg_addr == A_TXD && (!tx_full || tx_take);
  wire sts_wr   = reg_wr && reg_addr == A_STS;
  wire age_fire = char_tick && rx_cnt != '0 && !rx_push && !rx_pop &&
                  age_cnt == GW'(AGE_CHARS - 1);

  wire rx_rdy   = rx_cnt >= rx_thr;
  wire tx_rdy   = tx_cnt <= tx_thr;
  wire data_rdy = rx_cnt != '0;
  wire [3:0] sts = {brk_sts, tx_rdy, age_sts, rx_rdy};

  assign irq      = |(sts & irq_en);
  assign tx_valid = tx_cnt != '0;
  assign tx_byte  = tx_mem[tx_rp];

  always_ff @(posedge clk) begin
    if (rx_wr) rx_mem[rx_wp] <= {rx_brk, 1'b0, rx_par_err, rx_frm_err, rx_char};
    if (rx_ovr) rx_mem[rx_wp - AW'(1)][10] <= 1'b1;
    if (tx_wr) tx_mem[tx_wp] <= reg_wdata[7:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_wp   <= '0;
      rx_rp   <= '0;
      rx_cnt  <= '0;
      tx_wp   <= '0;
      tx_rp   <= '0;
      tx_cnt  <= '0;
      age_cnt <= '0;
      age_sts <= 1'b0;
      brk_sts <= 1'b0;
      irq_en  <= '0;
      rx_thr  <= CW'(RX_THR_RST);
      tx_thr  <= CW'(TX_THR_RST);
    end else begin
      if (rx_wr) rx_wp <= rx_wp + AW'(1);
      if (rx_pop) rx_rp <= rx_rp + AW'(1);
      rx_cnt <= rx_cnt + CW'(rx_wr) - CW'(rx_pop);
      if (tx_wr) tx_wp <= tx_wp + AW'(1);
      if (tx_take) tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + CW'(tx_wr) - CW'(tx_take);

      if (rx_push || rx_pop) age_cnt <= '0;
      else if (char_tick && rx_cnt != '0 && age_cnt != GW'(AGE_CHARS))
        age_cnt <= age_cnt + GW'(1);

      age_sts <= (age_sts && !(sts_wr && reg_wdata[1])) || age_fire;
      brk_sts <= (brk_sts && !(sts_wr && reg_wdata[3])) || (rx_push && rx_brk);

      if (reg_wr && reg_addr == A_ENA) irq_en <= reg_wdata[3:0];
      if (reg_wr && reg_addr == A_THR) begin
        rx_thr <= reg_wdata[CW-1:0];
        tx_thr <= reg_wdata[8 +: CW];
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_RXD: if (data_rdy) reg_rdata = {16'h0, 1'b1, 3'b0, rx_mem[rx_rp]};
      A_STS: reg_rdata = {27'h0, data_rdy, sts};
      A_ENA: reg_rdata = {28'h0, irq_en};
      A_THR: begin
        reg_rdata[CW-1:0]  = rx_thr;
        reg_rdata[8 +: CW] = tx_thr;
      end
      A_LVL: begin
        reg_rdata[CW-1:0]  = rx_cnt;
        reg_rdata[8 +: CW] = tx_cnt;
      end
      default: reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/uart_fifo_irq_chk.sv
module uart_fifo_irq_chk #(
  parameter int DEPTH = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        rx_push,
  input logic        rx_brk,
  input logic        reg_wr,
  input logic [2:0]  reg_addr,
  input logic [31:0] reg_wdata,
  input logic        char_tick,
  input logic        rx_pop,
  input logic [$clog2(DEPTH):0] rx_cnt,
  input logic [$clog2(DEPTH):0] tx_cnt,
  input logic        age_sts,
  input logic        brk_sts,
  input logic [3:0]  irq_en,
  input logic        irq
);
  localparam int CW = $clog2(DEPTH) + 1;
  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  a_r1_rx_bound: assert property (@(posedge clk) disable iff (!rst_n) rx_cnt <= FULL);
  a_r1_tx_bound: assert property (@(posedge clk) disable iff (!rst_n) tx_cnt <= FULL);
  a_r10_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_cnt == FULL && !rx_pop |=> rx_cnt == FULL);
  a_r6_age_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(age_sts) |-> $past(rx_cnt) != '0);
  a_r7_break_sets: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && rx_brk |=> brk_sts);
  a_r8_age_clear: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd2 && reg_wdata[1] && !char_tick |=> !age_sts);
  a_r9_break_irq: assert property (@(posedge clk) disable iff (!rst_n)
    brk_sts && irq_en[3] |-> irq);
  a_r9_quiet_irq: assert property (@(posedge clk) disable iff (!rst_n)
    irq_en == 4'h0 |-> !irq);
endmodule

bind uart_fifo_irq uart_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_push(rx_push), .rx_brk(rx_brk),
  .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .char_tick(char_tick), .rx_pop(rx_pop), .rx_cnt(rx_cnt), .tx_cnt(tx_cnt),
  .age_sts(age_sts), .brk_sts(brk_sts), .irq_en(irq_en), .irq(irq)
);

// File: tb/test_uart_fifo_irq.sv
module test_uart_fifo_irq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic rx_push = 1'b0, rx_frm_err = 1'b0, rx_par_err = 1'b0, rx_brk = 1'b0;
  logic [7:0] rx_char = '0;
  logic tx_pop = 1'b0, char_tick = 1'b0;
  logic [7:0] tx_byte;
  logic tx_valid, irq;

  int checks = 0, fails = 0;
  logic [15:0] rxq[$];
  logic [7:0]  txq[$];
  logic [31:0] d;

  always #5 clk = ~clk;

  uart_fifo_irq i_uart_fifo_irq (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rx_push(rx_push), .rx_char(rx_char), .rx_frm_err(rx_frm_err),
    .rx_par_err(rx_par_err), .rx_brk(rx_brk), .tx_pop(tx_pop),
    .tx_byte(tx_byte), .tx_valid(tx_valid), .char_tick(char_tick), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic push_rx(input logic [7:0] c, input logic f, input logic p, input logic b);
    logic [15:0] t;
    rx_push = 1'b1; rx_char = c; rx_frm_err = f; rx_par_err = p; rx_brk = b;
    @(negedge clk);
    rx_push = 1'b0; rx_frm_err = 1'b0; rx_par_err = 1'b0; rx_brk = 1'b0;
    if (rxq.size() < 32) rxq.push_back({4'b1000, b, 1'b0, p, f, c});
    else begin
      t = rxq[rxq.size() - 1];
      t[10] = 1'b1;
      rxq[rxq.size() - 1] = t;
    end
  endtask

  task automatic mon_rx(input string req);
    logic [31:0] v;
    logic [15:0] e;
    rd(3'd0, v);
    e = rxq.pop_front();
    chk(req, v, {16'h0, e});
  endtask

  task automatic send_tx(input logic [7:0] b);
    wr(3'd1, {24'h0, b});
    if (txq.size() < 32) txq.push_back(b);
  endtask

  task automatic mon_tx(input string req);
    logic [7:0] e;
    e = txq.pop_front();
    chk(req, {31'h0, tx_valid}, 32'h1);
    chk(req, {24'h0, tx_byte}, {24'h0, e});
    tx_pop = 1'b1;
    @(negedge clk);
    tx_pop = 1'b0;
  endtask

  task automatic tick();
    char_tick = 1'b1;
    @(negedge clk);
    char_tick = 1'b0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    rd(3'd5, d); chk("R1 reset levels", d, 32'h0);
    rd(3'd2, d); chk("R4 reset status", d, 32'h4);
    rd(3'd4, d); chk("R3 R4 reset thresholds", d, 32'h0818);
    chk("R9 reset irq", {31'h0, irq}, 32'h0);
    chk("R11 reset tx_valid", {31'h0, tx_valid}, 32'h0);

    push_rx(8'h41, 1'b1, 1'b0, 1'b0);
    push_rx(8'h42, 1'b0, 1'b1, 1'b0);
    push_rx(8'h43, 1'b0, 1'b0, 1'b0);
    rd(3'd2, d); chk("R5 data present", d & 32'h11, 32'h10);
    repeat (3) mon_rx("R2 entry format");
    rd(3'd0, d); chk("R2 empty read", d, 32'h0);
    rd(3'd5, d); chk("R2 empty read level", d, 32'h0);
    rd(3'd2, d); chk("R5 data gone", d & 32'h10, 32'h0);

    for (int i = 0; i < 23; i++) push_rx(8'(i), 1'b0, 1'b0, 1'b0);
    rd(3'd2, d); chk("R3 below threshold", d & 32'h1, 32'h0);
    push_rx(8'h77, 1'b0, 1'b0, 1'b0);
    rd(3'd2, d); chk("R3 at threshold", d & 32'h1, 32'h1);
    wr(3'd3, 32'h1);
    chk("R9 rx ready irq", {31'h0, irq}, 32'h1);
    wr(3'd3, 32'h0);
    for (int i = 0; i < 8; i++) push_rx(8'(8'h80 + i), 1'b0, 1'b0, 1'b0);
    rd(3'd5, d); chk("R1 rx full level", d, 32'h20);
    push_rx(8'hEE, 1'b0, 1'b0, 1'b0);
    rd(3'd5, d); chk("R10 drop keeps level", d, 32'h20);
    while (rxq.size() > 0) mon_rx("R10 drain with overrun mark");

    push_rx(8'h51, 1'b0, 1'b0, 1'b0);
    repeat (7) tick();
    rd(3'd2, d); chk("R6 seven idle ticks", d & 32'h2, 32'h0);
    tick();
    rd(3'd2, d); chk("R6 eighth idle tick", d & 32'h2, 32'h2);
    wr(3'd2, 32'h2);
    rd(3'd2, d); chk("R8 aging cleared", d & 32'h2, 32'h0);
    push_rx(8'h52, 1'b0, 1'b0, 1'b0);
    repeat (5) tick();
    push_rx(8'h53, 1'b0, 1'b0, 1'b0);
    repeat (7) tick();
    rd(3'd2, d); chk("R6 restart on push", d & 32'h2, 32'h0);
    tick();
    rd(3'd2, d); chk("R6 fire after restart", d & 32'h2, 32'h2);
    wr(3'd3, 32'h2);
    chk("R9 aging irq", {31'h0, irq}, 32'h1);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, d); chk("R8 all ones clear", d & 32'hA, 32'h0);
    repeat (3) mon_rx("R2 aging drain");

    push_rx(8'h00, 1'b1, 1'b0, 1'b1);
    rd(3'd2, d); chk("R7 break status", d & 32'h8, 32'h8);
    wr(3'd3, 32'h8);
    chk("R9 break alone irq", {31'h0, irq}, 32'h1);
    wr(3'd2, 32'h8);
    chk("R8 break cleared irq", {31'h0, irq}, 32'h0);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'h0801);
    rd(3'd2, d); chk("R3 lowered threshold", d & 32'h1, 32'h1);
    wr(3'd2, 32'h15);
    rd(3'd2, d); chk("R8 level bits unaffected", d & 32'h15, 32'h15);
    wr(3'd4, 32'h0818);
    mon_rx("R7 break entry");

    for (int i = 0; i < 10; i++) send_tx(8'(8'hA0 + i));
    rd(3'd5, d); chk("R1 tx level", d, 32'h0A00);
    rd(3'd2, d); chk("R4 above threshold", d & 32'h4, 32'h0);
    repeat (2) mon_tx("R11 order");
    rd(3'd2, d); chk("R4 at threshold", d & 32'h4, 32'h4);
    wr(3'd3, 32'h4);
    chk("R9 tx ready irq", {31'h0, irq}, 32'h1);
    wr(3'd3, 32'h0);
    while (txq.size() > 0) mon_tx("R11 drain");
    chk("R11 empty", {31'h0, tx_valid}, 32'h0);

    for (int i = 0; i < 33; i++) send_tx(8'(i * 3));
    rd(3'd5, d); chk("R1 tx full drop", d, 32'h2000);
    while (txq.size() > 0) mon_tx("R1 tx drain after drop");
    chk("R1 dropped byte absent", {31'h0, tx_valid}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule